// File: doc/BRIEF.md
# Serial Digital Potentiometer Loader

This block writes new wiper codes into a daisy chain of dual 256-position digital potentiometers over a three-wire serial link. The default chain has two devices, so there are four wipers. A host presents four 8-bit codes and pulses `start`. The block then drives the select line high and clocks out a fixed frame of 34 bits, 17 for each device. At the same time it captures the bits that the chain returns; these are the settings that were held before the load. After the last bit it drops select, and the devices commit the new values on that falling edge.

The captured old settings are unpacked into four readback codes and are valid while `done` pulses. The serial clock is derived from the system clock: each of its phases lasts `CLK_DIV` system cycles. The serial clock idles low. A single state machine controls the load. It has four states:
- `ST_IDLE`: waiting for a start request.
- `ST_LOW`: serial clock low, data being set up.
- `ST_HIGH`: serial clock high, data being sampled.
- `ST_DONE`: one cycle after select falls.

The transitions are:
- idle to low on an accepted start;
- low to high when the phase timer expires;
- high back to low at the end of a bit;
- high to done after the last bit;
- done to idle unconditionally.

Top module: `dpot_loader`

## Requirements
- R1: During and directly after reset, `sel`, `sclk`, `sdo`, `busy` and `done` are all low.
- R2: A `start` pulse seen in idle raises `sel` and `busy` on the next clock edge. `sel` then stays high for exactly 68*CLK_DIV cycles (34 bits).
- R3: `sclk` is low whenever `sel` is low. During a load, every low phase and every high phase lasts CLK_DIV cycles, beginning with a low phase, for 34 rising edges in total.
- R4: Wiper k is taken from `wiper_in[8k+7:8k]`, and device d holds wipers 2d (wiper 0) and 2d+1 (wiper 1). The frame sends device 1 first and then device 0. Each 17-bit device segment is sent in this order: a don't-care bit driven as 0, then its wiper 1 code MSB first, then its wiper 0 code MSB first.
- R5: `sdo` is valid for the whole low phase that comes before each rising `sclk` edge, and it holds steady while `sclk` is high. Outside a load, `sdo` is 0.
- R6: `sdi` is sampled when `sclk` rises. The 34 returned bits are decoded with the same layout as R4 into `readback[8k+7:8k]` for wiper k, and the result is valid while `done` is high.
- R7: `done` is high for exactly one cycle, which is the first cycle with `sel` low after a load. `busy` falls one cycle after that.
- R8: A `start` that arrives while `busy` is high is ignored. Changes to `wiper_in` after a start has been accepted do not affect the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Load request, acted on only in idle |
| wiper_in | input | 32 | Four new wiper codes, wiper k at bits 8k+7:8k |
| sdi | input | 1 | Bit returned from the end of the chain |
| sel | output | 1 | Chain select, high for the whole frame |
| sclk | output | 1 | Serial clock, idles low |
| sdo | output | 1 | Serial data to the chain |
| busy | output | 1 | Load in progress |
| done | output | 1 | One-cycle pulse ending a load |
| readback | output | 32 | Previous wiper codes captured from the chain |

## Verification
Every output is registered, so when a start is accepted at an edge, `sel` and `busy` are high in the cycle that follows. After that, the serial clock level and the data bit are a fixed function of how many cycles have passed: bit b is on `sdo` during cycles 1+2b*CLK_DIV through (2b+2)*CLK_DIV. `done` and the readback codes are due 68*CLK_DIV+1 cycles after the accepting edge, and `busy` drops one cycle after that. The bench counts cycles from the accepting edge in a behavioural model, compares every output against it at each falling clock edge, and models the potentiometer chain itself so that the returned bits are the codes that the previous load wrote.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_DONE
    } ld_state_t;
endpackage

// File: rtl/dpot_phase_timer.sv
module dpot_phase_timer #(
    parameter int CLK_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assert_phase_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
    assert_idle_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt == '0);
endmodule

// File: rtl/dpot_frame_tx.sv
module dpot_frame_tx #(
    parameter int NUM_DEV = 2,
    parameter int WIPERS_PER_DEV = 2,
    parameter int CODE_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic shift,
    input  logic [NUM_DEV*WIPERS_PER_DEV*CODE_W-1:0] codes,
    output logic bit_out
);
    localparam int DEV_BITS   = 1 + WIPERS_PER_DEV * CODE_W;
    localparam int FRAME_BITS = NUM_DEV * DEV_BITS;

    logic [FRAME_BITS-1:0] frame;
    logic [FRAME_BITS-1:0] sr;

    for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
        assign frame[d*DEV_BITS + DEV_BITS - 1] = 1'b0;
        for (genvar w = 0; w < WIPERS_PER_DEV; w++) begin : g_wiper
            assign frame[d*DEV_BITS + w*CODE_W +: CODE_W] =
                codes[(d*WIPERS_PER_DEV + w)*CODE_W +: CODE_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr <= '0;
        end else if (load) begin
            sr <= frame;
        end else if (shift) begin
            sr <= {sr[FRAME_BITS-2:0], 1'b0};
        end
    end

    assign bit_out = sr[FRAME_BITS-1];

    assert_no_load_shift_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && shift));
endmodule

// File: rtl/dpot_frame_rx.sv
module dpot_frame_rx #(
    parameter int NUM_DEV = 2,
    parameter int WIPERS_PER_DEV = 2,
    parameter int CODE_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sample,
    input  logic sdi,
    input  logic commit,
    output logic [NUM_DEV*WIPERS_PER_DEV*CODE_W-1:0] readback
);
    localparam int DEV_BITS   = 1 + WIPERS_PER_DEV * CODE_W;
    localparam int FRAME_BITS = NUM_DEV * DEV_BITS;
    localparam int RB_W       = NUM_DEV * WIPERS_PER_DEV * CODE_W;

    logic [FRAME_BITS-1:0] sr;
    logic [RB_W-1:0]       unpacked;

    for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
        for (genvar w = 0; w < WIPERS_PER_DEV; w++) begin : g_wiper
            assign unpacked[(d*WIPERS_PER_DEV + w)*CODE_W +: CODE_W] =
                sr[d*DEV_BITS + w*CODE_W +: CODE_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr       <= '0;
            readback <= '0;
        end else begin
            if (sample) begin
                sr <= {sr[FRAME_BITS-2:0], sdi};
            end
            if (commit) begin
                readback <= unpacked;
            end
        end
    end

    assert_no_sample_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample && commit));
endmodule

// File: rtl/dpot_loader.sv
module dpot_loader
    import dpot_pkg::*;
#(
    parameter int CLK_DIV        = 2,
    parameter int NUM_DEV        = 2,
    parameter int WIPERS_PER_DEV = 2,
    parameter int CODE_W         = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic [NUM_DEV*WIPERS_PER_DEV*CODE_W-1:0] wiper_in,
    input  logic sdi,
    output logic sel,
    output logic sclk,
    output logic sdo,
    output logic busy,
    output logic done,
    output logic [NUM_DEV*WIPERS_PER_DEV*CODE_W-1:0] readback
);
    localparam int DEV_BITS   = 1 + WIPERS_PER_DEV * CODE_W;
    localparam int FRAME_BITS = NUM_DEV * DEV_BITS;
    localparam int BIT_W      = $clog2(FRAME_BITS);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_BITS - 1);

    ld_state_t      state, next_state;
    logic [BIT_W-1:0] bit_cnt;
    logic           tick;
    logic           load, shift_bit, sample_bit, last_bit, tx_bit;

    assign load       = (state == ST_IDLE) && start;
    assign sample_bit = (state == ST_LOW) && tick;
    assign shift_bit  = (state == ST_HIGH) && tick;
    assign last_bit   = (bit_cnt == LAST_BIT);

    dpot_phase_timer #(.CLK_DIV(CLK_DIV)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (sel),
        .tick  (tick)
    );

    dpot_frame_tx #(
        .NUM_DEV(NUM_DEV), .WIPERS_PER_DEV(WIPERS_PER_DEV), .CODE_W(CODE_W)
    ) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .shift   (shift_bit),
        .codes   (wiper_in),
        .bit_out (tx_bit)
    );

    dpot_frame_rx #(
        .NUM_DEV(NUM_DEV), .WIPERS_PER_DEV(WIPERS_PER_DEV), .CODE_W(CODE_W)
    ) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample   (sample_bit),
        .sdi      (sdi),
        .commit   (shift_bit && last_bit),
        .readback (readback)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= next_state;
        end
    end

    // bit position within the frame
    always_ff @(posedge clk) begin
        if (!rst_n || state == ST_IDLE) begin
            bit_cnt <= '0;
        end else if (shift_bit && !last_bit) begin
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    always_comb begin
        next_state = state;
        unique case (state)
            ST_IDLE: if (start)    next_state = ST_LOW;
            ST_LOW:  if (tick)     next_state = ST_HIGH;
            ST_HIGH: if (tick)     next_state = last_bit ? ST_DONE : ST_LOW;
            ST_DONE:               next_state = ST_IDLE;
            default:               next_state = ST_IDLE;
        endcase
    end

    // outputs decoded from the state
    always_comb begin
        sel  = (state == ST_LOW) || (state == ST_HIGH);
        sclk = (state == ST_HIGH);
        busy = (state != ST_IDLE);
        done = (state == ST_DONE);
        sdo  = sel && tx_bit;
    end

    assert_sclk_needs_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> sel);
    assert_sdo_steady_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(sdo));
    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_follows_sel_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $fell(sel));
    assert_busy_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    assert_sel_from_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel) |-> !$past(busy));
endmodule

// File: tb/test_dpot_loader.sv
module test_dpot_loader;
    localparam int DIV   = 2;
    localparam int NBITS = 34;
    localparam int SELN  = 2 * NBITS * DIV;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] wiper_in = '0;
    logic        sdi;
    logic        sel, sclk, sdo, busy, done;
    logic [31:0] readback;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    dpot_loader #(.CLK_DIV(DIV)) i_dpot_loader (
        .clk(clk), .rst_n(rst_n), .start(start), .wiper_in(wiper_in),
        .sdi(sdi), .sel(sel), .sclk(sclk), .sdo(sdo), .busy(busy),
        .done(done), .readback(readback)
    );

    // bit j of a frame for four codes, per R4
    function automatic logic frame_bit(logic [31:0] c, int j);
        int dev = (j < 17) ? 1 : 0;
        int o = j % 17;
        int w;
        int pos;
        if (o == 0) return 1'b0;
        w = (o <= 8) ? 1 : 0;
        pos = 7 - ((o - 1) % 8);
        return c[(dev*2 + w)*8 + pos];
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // chain model: old contents come back while new ones shift in
    logic [31:0] chain_codes = 32'hF00F_3CA5;
    logic        cap [NBITS];
    int          k = 0;

    always_comb sdi = (sel && k < NBITS) ? frame_bit(chain_codes, k) : 1'b0;

    always @(posedge sel) k = 0;
    always @(posedge sclk) begin
        if (k < NBITS) cap[k] = sdo;
        k = k + 1;
    end

    // reference model: cycles since accepted start
    int          t = 0;
    logic [31:0] cur = '0;
    logic [31:0] exp_rb = '0;
    logic [31:0] prev_chain;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            t = 0;
        end else if (t == 0) begin
            if (start) begin
                t = 1;
                cur = wiper_in;
                exp_rb = chain_codes;
            end
        end else begin
            t = t + 1;
            if (t > SELN + 1) t = 0;
        end
    end

    always @(negedge sel) begin
        if (rst_n) begin
            for (int j = 0; j < NBITS; j++) begin
                check("R4 chain capture", {31'd0, cap[j]}, {31'd0, frame_bit(cur, j)});
            end
            prev_chain = chain_codes;
            chain_codes = cur;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            logic e_sel, e_sclk, e_sdo;
            e_sel  = (t >= 1) && (t <= SELN);
            e_sclk = e_sel && ((((t - 1) / DIV) % 2) == 1);
            e_sdo  = e_sel ? frame_bit(cur, (t - 1) / (2*DIV)) : 1'b0;
            check("R2 sel", {31'd0, sel}, {31'd0, e_sel});
            check("R3 sclk", {31'd0, sclk}, {31'd0, e_sclk});
            check("R4/R5 sdo", {31'd0, sdo}, {31'd0, e_sdo});
            check("R7 busy", {31'd0, busy}, {31'd0, t != 0});
            check("R7 done", {31'd0, done}, {31'd0, t == SELN + 1});
            if (t == SELN + 1) check("R6 readback", readback, exp_rb);
        end
    end

    task automatic do_load(logic [31:0] codes);
        @(negedge clk);
        wiper_in = codes;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 sel", {31'd0, sel}, 32'd0);
        check("R1 sclk", {31'd0, sclk}, 32'd0);
        check("R1 sdo", {31'd0, sdo}, 32'd0);
        check("R1 busy", {31'd0, busy}, 32'd0);
        check("R1 done", {31'd0, done}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", {30'd0, sel, busy}, 32'd0);

        do_load(32'h1234_5678);
        do_load(32'hFF00_8001);

        // R8: start pulses and code changes during busy are ignored
        @(negedge clk);
        wiper_in = 32'hA55A_C33C;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        wiper_in = 32'h0000_0000;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (60) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (busy) @(negedge clk);
        check("R8 chain got first codes", chain_codes, 32'hA55A_C33C);
        @(negedge clk);

        do_load(32'h0000_0000);
        do_load(32'hFFFF_FFFF);

        // start held high: back-to-back loads, each accepted only from idle
        @(negedge clk);
        wiper_in = 32'h8001_7E81;
        start = 1'b1;
        repeat (2 * (SELN + 2) + 4) @(negedge clk);
        start = 1'b0;
        while (busy) @(negedge clk);
        @(negedge clk);
        check("R6 chain holds last codes", chain_codes, 32'h8001_7E81);
        check("R8 previous chain codes", prev_chain, 32'h8001_7E81);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule